// File: doc/BRIEF.md
# Grid Position Stepper

This block keeps a pointer on an 8-by-8 grid and moves it by exactly one cell for each step command. A 2-bit direction code selects one of four headings. The move is committed when the drive strobe falls. The current position leaves the block as two 3-bit coordinates, one horizontal and one vertical. Moving right raises the horizontal coordinate and moving down raises the vertical coordinate.

The drive strobe is sampled by the system clock. Its falling edge is found by comparing it with a registered copy. The direction code is read only in the clock cycle where that edge is seen, so it may change freely at any other time. A move that would leave the grid is dropped, and the coordinate stays at its edge. A secondary reset input is provided but has no effect on the position. Only the synchronous system reset returns the pointer to the origin.

Top module: `grid_stepper`

## Requirements
- R1: While `rst` is high at a rising clock edge, both `pos_x` and `pos_y` become 0 after that edge.
- R2: The position changes only at the clock edge where `drive` is sampled low after having been sampled high at the previous edge. A rising `drive` or a steady `drive` leaves both coordinates unchanged.
- R3: Direction code `dir` is decoded as 2'b00 = up (`pos_y` minus 1), 2'b01 = right (`pos_x` plus 1), 2'b10 = left (`pos_x` minus 1), 2'b11 = down (`pos_y` plus 1).
- R4: One falling edge of `drive` gives exactly one step, however many cycles `drive` then stays low.
- R5: A step that would take a coordinate below 0 or above 7 is ignored, and that coordinate keeps its value.
- R6: `dir` is read only at the edge where the fall of `drive` is detected. Changing `dir` at any other time moves nothing.
- R7: The `aux_rst` input has no effect on either coordinate, whether it is high, low or toggling.
- R8: A horizontal step leaves `pos_y` unchanged, and a vertical step leaves `pos_x` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous system reset, active high; puts the pointer at (0,0) |
| drive | input | 1 | Step strobe; its falling edge commits one move |
| dir | input | 2 | Direction code: 00 up, 01 right, 10 left, 11 down |
| aux_rst | input | 1 | Secondary reset input with no effect on the position |
| pos_x | output | 3 | Horizontal coordinate, 0 at left, 7 at right |
| pos_y | output | 3 | Vertical coordinate, 0 at top, 7 at bottom |

## Verification
The bench changes `drive` and `dir` only on falling clock edges. A fall of `drive` is seen at the next rising edge, and the new coordinate is registered at that same edge. The bench therefore reads the coordinates one falling edge after it lowers `drive`, which is one cycle after the stimulus. It also reads them in the half cycle after each raise of `drive` and after each change of `dir` or `aux_rst`. At those points it expects no change. Reset is checked one edge after `rst` is applied.

// File: rtl/grid_stepper_pkg.sv
package grid_stepper_pkg;

  typedef enum logic [1:0] {
    DIR_UP    = 2'b00,
    DIR_RIGHT = 2'b01,
    DIR_LEFT  = 2'b10,
    DIR_DOWN  = 2'b11
  } dir_e;

  // Axis index used for the per-axis step requests.
  localparam int AXIS_X   = 0;
  localparam int AXIS_Y   = 1;
  localparam int N_AXES   = 2;

  typedef struct packed {
    logic [N_AXES-1:0] inc;
    logic [N_AXES-1:0] dec;
  } step_req_t;

endpackage

// File: rtl/gs_fall_detect.sv
module gs_fall_detect (
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  output logic fall
);
  logic strobe_q;

  always_ff @(posedge clk) begin
    if (rst) strobe_q <= 1'b0;
    else     strobe_q <= strobe;
  end

  assign fall = strobe_q & ~strobe;
endmodule

// File: rtl/gs_dir_decode.sv
module gs_dir_decode
  import grid_stepper_pkg::*;
(
  input  logic      fire,
  input  logic [1:0] dir,
  output step_req_t req
);
  always_comb begin
    req = '0;
    if (fire) begin
      unique case (dir_e'(dir))
        DIR_UP:    req.dec[AXIS_Y] = 1'b1;
        DIR_RIGHT: req.inc[AXIS_X] = 1'b1;
        DIR_LEFT:  req.dec[AXIS_X] = 1'b1;
        DIR_DOWN:  req.inc[AXIS_Y] = 1'b1;
        default:   req = '0;
      endcase
    end
  end
endmodule

// File: rtl/gs_axis.sv
module gs_axis #(
  parameter int COORD_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inc,
  input  logic               dec,
  output logic [COORD_W-1:0] coord
);
  localparam logic [COORD_W-1:0] C_MAX = {COORD_W{1'b1}};
  localparam logic [COORD_W-1:0] C_ONE = {{(COORD_W-1){1'b0}}, 1'b1};

  function automatic logic [COORD_W-1:0] sat_up(input logic [COORD_W-1:0] v);
    return (v == C_MAX) ? v : v + C_ONE;
  endfunction

  function automatic logic [COORD_W-1:0] sat_down(input logic [COORD_W-1:0] v);
    return (v == '0) ? v : v - C_ONE;
  endfunction

  always_ff @(posedge clk) begin
    if (rst)      coord <= '0;
    else if (inc) coord <= sat_up(coord);
    else if (dec) coord <= sat_down(coord);
  end
endmodule

// File: rtl/grid_stepper.sv
module grid_stepper
  import grid_stepper_pkg::*;
#(
  parameter int COORD_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               drive,
  input  logic [1:0]         dir,
  input  logic               aux_rst,
  output logic [COORD_W-1:0] pos_x,
  output logic [COORD_W-1:0] pos_y
);
  logic      fall_evt;
  step_req_t step_req;
  logic [COORD_W-1:0] coord [N_AXES];

  // Secondary reset deliberately has no path into the position state.
  logic unused_aux;
  assign unused_aux = aux_rst;

  gs_fall_detect u_fall (
    .clk    (clk),
    .rst    (rst),
    .strobe (drive),
    .fall   (fall_evt)
  );

  gs_dir_decode u_dec (
    .fire (fall_evt),
    .dir  (dir),
    .req  (step_req)
  );

  for (genvar a = 0; a < N_AXES; a++) begin : g_axis
    gs_axis #(.COORD_W(COORD_W)) u_axis (
      .clk   (clk),
      .rst   (rst),
      .inc   (step_req.inc[a]),
      .dec   (step_req.dec[a]),
      .coord (coord[a])
    );
  end

  assign pos_x = coord[AXIS_X];
  assign pos_y = coord[AXIS_Y];
endmodule

// File: rtl/grid_stepper_chk.sv
module grid_stepper_chk #(
  parameter int COORD_W = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               fall_evt,
  input logic [1:0]         dir,
  input logic [COORD_W-1:0] pos_x,
  input logic [COORD_W-1:0] pos_y
);
  localparam logic [COORD_W-1:0] C_MAX = {COORD_W{1'b1}};
  localparam logic [COORD_W-1:0] C_ONE = {{(COORD_W-1){1'b0}}, 1'b1};

  // R1
  reset_origin_chk: assert property (@(posedge clk)
    rst |=> (pos_x == '0 && pos_y == '0));

  // R2
  no_idle_move_chk: assert property (@(posedge clk) disable iff (rst)
    !fall_evt |=> ($stable(pos_x) && $stable(pos_y)));

  // R3
  right_step_chk: assert property (@(posedge clk) disable iff (rst)
    (fall_evt && dir == 2'b01 && pos_x != C_MAX) |=> pos_x == $past(pos_x) + C_ONE);

  // R3
  down_step_chk: assert property (@(posedge clk) disable iff (rst)
    (fall_evt && dir == 2'b11 && pos_y != C_MAX) |=> pos_y == $past(pos_y) + C_ONE);

  // R5
  left_wall_chk: assert property (@(posedge clk) disable iff (rst)
    (fall_evt && dir == 2'b10 && pos_x == '0) |=> pos_x == '0);

  // R5
  bottom_wall_chk: assert property (@(posedge clk) disable iff (rst)
    (fall_evt && dir == 2'b11 && pos_y == C_MAX) |=> pos_y == C_MAX);

  // R8
  horiz_keeps_y_chk: assert property (@(posedge clk) disable iff (rst)
    (fall_evt && (dir[1] ^ dir[0])) |=> $stable(pos_y));

  // R8
  vert_keeps_x_chk: assert property (@(posedge clk) disable iff (rst)
    (fall_evt && !(dir[1] ^ dir[0])) |=> $stable(pos_x));
endmodule

bind grid_stepper grid_stepper_chk #(.COORD_W(COORD_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .fall_evt (fall_evt),
  .dir      (dir),
  .pos_x    (pos_x),
  .pos_y    (pos_y)
);

// File: tb/grid_stepper_bench.sv
`timescale 1ns/1ps
module grid_stepper_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       drive = 1'b0;
  logic [1:0] dir = 2'b00;
  logic       aux_rst = 1'b0;
  logic [2:0] pos_x, pos_y;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  grid_stepper u_grid_stepper (
    .clk(clk), .rst(rst), .drive(drive), .dir(dir),
    .aux_rst(aux_rst), .pos_x(pos_x), .pos_y(pos_y)
  );

  // Vector: {dir[1:0], exp_x[2:0], exp_y[2:0]} after one strobe, from origin.
  localparam logic [7:0] VEC [10] = '{
    {2'b00, 3'd0, 3'd0},  // up at top wall (R5)
    {2'b10, 3'd0, 3'd0},  // left at left wall (R5)
    {2'b01, 3'd1, 3'd0},  // right (R3)
    {2'b01, 3'd2, 3'd0},
    {2'b11, 3'd2, 3'd1},  // down (R3)
    {2'b11, 3'd2, 3'd2},
    {2'b10, 3'd1, 3'd2},  // left (R3)
    {2'b00, 3'd1, 3'd1},  // up (R3)
    {2'b01, 3'd2, 3'd1},
    {2'b11, 3'd2, 3'd2}
  };

  task automatic check(input string req, input logic [2:0] ex, input logic [2:0] ey);
    n_chk++;
    if (pos_x !== ex || pos_y !== ey) begin
      n_bad++;
      $display("FAIL %s: got (%0d,%0d) expected (%0d,%0d)", req, pos_x, pos_y, ex, ey);
    end
  endtask

  // Raise drive, then lower it; returns on the falling clock edge after the move.
  task automatic strobe(input logic [1:0] d, input int low_cycles);
    @(negedge clk); dir = d; drive = 1'b1;
    @(negedge clk); drive = 1'b0;
    repeat (low_cycles) @(negedge clk);
  endtask

  initial begin
    logic [2:0] sx, sy;
    repeat (3) @(negedge clk);
    check("R1", 3'd0, 3'd0);
    rst = 1'b0;

    for (int i = 0; i < 10; i++) begin
      strobe(VEC[i][7:6], 1);
      check("R3/R5/R8 table", VEC[i][5:3], VEC[i][2:0]);
    end

    // R2: rising edge alone moves nothing
    @(negedge clk); dir = 2'b01; drive = 1'b1;
    @(negedge clk);
    check("R2 rise", 3'd2, 3'd2);
    @(negedge clk);
    check("R2 high", 3'd2, 3'd2);
    // R6: dir changes while drive is high
    dir = 2'b11; @(negedge clk); dir = 2'b00; @(negedge clk);
    check("R6 dir while high", 3'd2, 3'd2);
    dir = 2'b10; drive = 1'b0; @(negedge clk);
    check("R6 sampled at fall", 3'd1, 3'd2);
    // R6: dir changes while drive is low
    dir = 2'b01; @(negedge clk); dir = 2'b11; @(negedge clk);
    check("R6 dir while low", 3'd1, 3'd2);

    // R4: long low phase, single step
    strobe(2'b11, 8);
    check("R4 one step", 3'd1, 3'd3);

    // R5: run to right and bottom walls
    for (int i = 0; i < 9; i++) strobe(2'b01, 1);
    check("R5 right wall", 3'd7, 3'd3);
    for (int i = 0; i < 9; i++) strobe(2'b11, 1);
    check("R5 bottom wall", 3'd7, 3'd7);

    // R7: aux reset toggling, held and during a strobe
    aux_rst = 1'b1; repeat (3) @(negedge clk);
    check("R7 aux held", 3'd7, 3'd7);
    strobe(2'b00, 1);
    check("R7 aux during move", 3'd7, 3'd6);
    aux_rst = 1'b0; @(negedge clk); aux_rst = 1'b1; @(negedge clk); aux_rst = 1'b0;
    @(negedge clk);
    check("R7 aux toggle", 3'd7, 3'd6);

    // R8 independent axis behaviour at a wall
    strobe(2'b01, 1);
    check("R8 x wall keeps y", 3'd7, 3'd6);

    // Bench-side model walk of a mixed pattern (R3)
    sx = pos_x; sy = pos_y;
    for (int i = 0; i < 12; i++) begin
      logic [1:0] d;
      d = 2'(i * 3 + 1);
      strobe(d, 1 + (i % 3));
      case (d)
        2'b00: if (sy != 0) sy = sy - 1;
        2'b01: if (sx != 7) sx = sx + 1;
        2'b10: if (sx != 0) sx = sx - 1;
        default: if (sy != 7) sy = sy + 1;
      endcase
      check("R3 model walk", sx, sy);
    end

    // R1: reset mid-run, and drive dropping during reset does not move
    @(negedge clk); drive = 1'b1; rst = 1'b1;
    @(negedge clk); drive = 1'b0;
    @(negedge clk);
    check("R1 mid-run", 3'd0, 3'd0);
    rst = 1'b0; @(negedge clk);
    check("R1 after release", 3'd0, 3'd0);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule